// File: doc/BRIEF.md
# Pipeline Operand Bypass and Interlock Controller

This block decides, every cycle, where the operands of a five-stage integer pipeline come from and when the front of the pipe must wait. It compares the source register numbers of the instruction in decode and the instruction in execute against the destinations held in the three later pipeline registers. From that comparison it produces mux selects for the two ALU inputs, for the two inputs of a zero/equality comparator that resolves branches in decode, and for the store-data path in the memory stage.

Register reads happen in decode and register writes only at writeback, so only read-after-write dependences matter. Write-after-read and write-after-write cases cannot arise. When a dependence cannot be covered by a bypass, the block raises `stall`. The surrounding pipeline then holds PC and IF/ID and loads a no-op into the ID/EX control fields. There are two such cases. The first is a loaded value needed by the very next instruction. The second is a decode-stage branch that needs a result not yet out of execute. A branch that waits on a load must wait two cycles, so the block holds a single bit of state to extend that stall. This bit is the only reason it has a clock and reset.

Top module: `fwd_interlock`

## Requirements
- R1: Each of `alu_sel_a` and `alu_sel_b` reads 2'b10 (take EX/MEM) when the EX/MEM destination is written, is nonzero and equals that ALU source. Otherwise it reads 2'b01 (take MEM/WB) when the same holds for MEM/WB. Otherwise it reads 2'b00 (register file).
- R2: When both EX/MEM and MEM/WB match a source, every select picks EX/MEM (2'b10), the younger value.
- R3: A destination of register 0 never produces a nonzero select, never asserts `st_data_fwd` and never causes a stall.
- R4: `stall` is 1 when a load in EX (`idex_is_load`, `idex_wen`) writes a register that the decode instruction uses as its first source, or as its second source when it is not a store.
- R5: A store in decode whose data register (second source) is the destination of a load in EX does not stall. In the memory stage, `st_data_fwd` is 1 exactly when `exmem_is_store` is set and `exmem_sdata_reg` equals a written, nonzero MEM/WB destination.
- R6: A branch in decode that uses a register written by a non-load ALU instruction in EX stalls for one cycle. `br_sel_a` and `br_sel_b` use the same encoding as R1 (2'b10 EX/MEM, 2'b01 MEM/WB, 2'b00 register file), against the decode sources.
- R7: A branch in decode that uses the destination of a load in EX stalls in that cycle and in the next. In the cycle after that, it takes the loaded value from MEM/WB (select 2'b01) without stalling.
- R8: A non-branch instruction in decode that depends on a non-load instruction in EX does not stall.
- R9: A source whose use flag is 0 never causes a stall.
- R10: Synchronous active-low reset clears the extended branch-on-load stall, so no stall follows reset without a current cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_W | First source of the decode instruction |
| id_rs2 | input | REG_W | Second source of the decode instruction (store data for stores) |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store |
| id_is_branch | input | 1 | Decode instruction is a branch resolved in decode |
| ex_rs1 | input | REG_W | First ALU source of the execute instruction |
| ex_rs2 | input | REG_W | Second ALU source of the execute instruction |
| idex_rd | input | REG_W | Destination held in ID/EX |
| idex_wen | input | 1 | ID/EX instruction writes a register |
| idex_is_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | REG_W | Destination held in EX/MEM |
| exmem_wen | input | 1 | EX/MEM instruction writes a register |
| exmem_is_store | input | 1 | EX/MEM instruction is a store |
| exmem_sdata_reg | input | REG_W | Store-data register of the EX/MEM store |
| memwb_rd | input | REG_W | Destination held in MEM/WB |
| memwb_wen | input | 1 | MEM/WB instruction writes a register |
| alu_sel_a | output | 2 | Bypass select, ALU input A |
| alu_sel_b | output | 2 | Bypass select, ALU input B |
| br_sel_a | output | 2 | Bypass select, branch comparator input A |
| br_sel_b | output | 2 | Bypass select, branch comparator input B |
| st_data_fwd | output | 1 | Store data in MEM taken from MEM/WB |
| stall | output | 1 | Hold PC and IF/ID, inject a bubble into ID/EX |

## Verification
The hardest situation to reach is the second cycle of a branch-on-load stall. Nothing at the ports calls for a stall then, because the load has moved to EX/MEM and ID/EX holds a bubble. The stall comes only from the stored bit. The directed test builds that exact sequence one cycle at a time and checks for a stall in both cycles and a MEM/WB bypass in the third. A reset test sets up the same cause while reset is held and then checks that no stall follows the release.

// File: rtl/hz_pkg.sv
// Shared encodings for the bypass and interlock controller.
// Assumes a two-bit operand select feeding a three-input mux.
package hz_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,   // register file value
        SRC_WB  = 2'b01,   // MEM/WB result
        SRC_MEM = 2'b10    // EX/MEM result
    } byp_sel_e;
endpackage

// File: rtl/reg_match.sv
// Flags a live dependence: a written, nonzero destination equal to a source.
// Assumes register 0 is hardwired to zero and is never a real producer.
module reg_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] rd,
    input  logic             wen,
    output logic             hit
);
    // compare one producer against one consumer
    always_comb begin
        hit = wen && (rd != '0) && (rd == src);
    end
endmodule

// File: rtl/bypass_sel.sv
// Picks the operand source for one consumer from EX/MEM, MEM/WB or the
// register file. Assumes EX/MEM holds the younger of the two results.
module bypass_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wen,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    output logic [1:0]       sel
);
    logic hit_mem;
    logic hit_wb;

    reg_match #(.REG_W(REG_W)) u_m_mem (
        .src(src), .rd(exmem_rd), .wen(exmem_wen), .hit(hit_mem)
    );
    reg_match #(.REG_W(REG_W)) u_m_wb (
        .src(src), .rd(memwb_rd), .wen(memwb_wen), .hit(hit_wb)
    );

    // younger producer first, then older, then the register file
    always_comb begin
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end

    assert_young_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_wen && exmem_rd == src && src != '0) |-> sel == SRC_MEM);

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> sel == SRC_RF);

    assert_wb_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exmem_wen && exmem_rd == src) && memwb_wen && memwb_rd == src && src != '0)
        |-> sel == SRC_WB);
endmodule

// File: rtl/interlock.sv
// Raises the stall for load-use and decode-branch dependences on ID/EX.
// A branch that waits on a load gets one extra stall cycle from a stored bit,
// because the load is still in MEM when the first stall cycle ends.
// Assumes the pipeline turns a stall into a bubble in ID/EX and holds decode.
module interlock #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic             id_is_branch,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_wen,
    input  logic             idex_is_load,
    output logic             stall
);
    logic hit1;
    logic hit2;
    logic load_use;
    logic br_on_ex;
    logic br_on_load;
    logic pend_q;

    reg_match #(.REG_W(REG_W)) u_m_s1 (
        .src(id_rs1), .rd(idex_rd), .wen(idex_wen), .hit(hit1)
    );
    reg_match #(.REG_W(REG_W)) u_m_s2 (
        .src(id_rs2), .rd(idex_rd), .wen(idex_wen), .hit(hit2)
    );

    // classify the dependence of decode on the instruction in EX
    always_comb begin
        load_use   = idex_is_load &&
                     ((hit1 && id_use_rs1) || (hit2 && id_use_rs2 && !id_is_store));
        br_on_ex   = id_is_branch &&
                     ((hit1 && id_use_rs1) || (hit2 && id_use_rs2));
        br_on_load = br_on_ex && idex_is_load;
        stall      = load_use || br_on_ex || pend_q;
    end

    // remember a branch-on-load so the following cycle also stalls
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= br_on_load;
    end

    assert_two_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_on_load |=> stall);

    assert_zero_dest_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rd == '0 && !pend_q) |-> !stall);

    assert_store_data_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_store && !id_is_branch && !id_use_rs1 && !pend_q) |-> !stall);

    assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_use_rs1 && !id_use_rs2 && !pend_q) |-> !stall);
endmodule

// File: rtl/fwd_interlock.sv
// Top of the bypass and interlock controller: four operand selects (two ALU,
// two decode-branch), a MEM-stage store-data bypass and the pipeline stall.
// Assumes writes happen only at writeback, so only read-after-write matters.
module fwd_interlock
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_store,
    input  logic             id_is_branch,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_wen,
    input  logic             idex_is_load,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wen,
    input  logic             exmem_is_store,
    input  logic [REG_W-1:0] exmem_sdata_reg,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    output logic [1:0]       alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic [1:0]       br_sel_a,
    output logic [1:0]       br_sel_b,
    output logic             st_data_fwd,
    output logic             stall
);
    localparam int N_CONS = 4;   // ALU A, ALU B, branch A, branch B

    logic [REG_W-1:0] cons_src [N_CONS];
    logic [1:0]       cons_sel [N_CONS];
    logic             st_hit;

    // gather the consumer register numbers in a fixed order
    always_comb begin
        cons_src[0] = ex_rs1;
        cons_src[1] = ex_rs2;
        cons_src[2] = id_rs1;
        cons_src[3] = id_rs2;
    end

    for (genvar g = 0; g < N_CONS; g++) begin : g_byp
        bypass_sel #(.REG_W(REG_W)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (cons_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_wen(exmem_wen),
            .memwb_rd (memwb_rd),
            .memwb_wen(memwb_wen),
            .sel      (cons_sel[g])
        );
    end

    // drive the select outputs from the consumer array
    always_comb begin
        alu_sel_a = cons_sel[0];
        alu_sel_b = cons_sel[1];
        br_sel_a  = cons_sel[2];
        br_sel_b  = cons_sel[3];
    end

    reg_match #(.REG_W(REG_W)) u_m_store (
        .src(exmem_sdata_reg), .rd(memwb_rd), .wen(memwb_wen), .hit(st_hit)
    );

    // MEM-stage store data from the result leaving MEM/WB
    always_comb begin
        st_data_fwd = exmem_is_store && st_hit;
    end

    interlock #(.REG_W(REG_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .id_is_branch(id_is_branch),
        .idex_rd     (idex_rd),
        .idex_wen    (idex_wen),
        .idex_is_load(idex_is_load),
        .stall       (stall)
    );

    assert_store_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_is_store && memwb_wen && memwb_rd != '0 && memwb_rd == exmem_sdata_reg)
        |-> st_data_fwd);

    assert_store_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_sdata_reg == '0) |-> !st_data_fwd);
endmodule

// File: tb/fwd_interlock_test.sv
`timescale 1ns/1ps
module fwd_interlock_test;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, exmem_sdata_reg, memwb_rd;
    logic id_use_rs1, id_use_rs2, id_is_store, id_is_branch;
    logic idex_wen, idex_is_load, exmem_wen, exmem_is_store, memwb_wen;
    logic [1:0] alu_sel_a, alu_sel_b, br_sel_a, br_sel_b;
    logic st_data_fwd, stall;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fwd_interlock #(.REG_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_is_store(id_is_store), .id_is_branch(id_is_branch),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .idex_rd(idex_rd), .idex_wen(idex_wen), .idex_is_load(idex_is_load),
        .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_is_store(exmem_is_store),
        .exmem_sdata_reg(exmem_sdata_reg), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .br_sel_a(br_sel_a), .br_sel_b(br_sel_b),
        .st_data_fwd(st_data_fwd), .stall(stall)
    );

    // order: i1 i2 u1 u2 st br e1 e2 xr xwe xld mr mwe mst md wr wwe | fa fb ba bb sf stl | req
    typedef struct packed {
        logic [W-1:0] i1, i2; logic u1, u2, st, br;
        logic [W-1:0] e1, e2, xr; logic xwe, xld;
        logic [W-1:0] mr; logic mwe, mst; logic [W-1:0] md, wr; logic wwe;
        logic [1:0] fa, fb, ba, bb; logic sf, stl;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1: A from EX/MEM, B from MEM/WB
        '{5'd7,5'd8,1'b1,1'b1,1'b0,1'b0, 5'd3,5'd4,5'd9,1'b1,1'b0, 5'd3,1'b1,1'b0,5'd0,5'd4,1'b1, 2'b10,2'b01,2'b00,2'b00,1'b0,1'b0, 4'd1},
        // R2: both stages match, EX/MEM wins for ALU and branch A
        '{5'd5,5'd6,1'b1,1'b1,1'b0,1'b0, 5'd5,5'd5,5'd0,1'b0,1'b0, 5'd5,1'b1,1'b0,5'd0,5'd5,1'b1, 2'b10,2'b10,2'b10,2'b00,1'b0,1'b0, 4'd2},
        // R1: EX/MEM not writing, MEM/WB supplies
        '{5'd5,5'd6,1'b1,1'b1,1'b0,1'b0, 5'd5,5'd5,5'd0,1'b0,1'b0, 5'd5,1'b0,1'b0,5'd0,5'd5,1'b1, 2'b01,2'b01,2'b01,2'b00,1'b0,1'b0, 4'd1},
        // R3: register 0 everywhere, no select, no stall, no store bypass
        '{5'd0,5'd0,1'b1,1'b1,1'b0,1'b1, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1,5'd0,5'd0,1'b1, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0, 4'd3},
        // R4: load-use on first source
        '{5'd6,5'd2,1'b1,1'b0,1'b0,1'b0, 5'd1,5'd2,5'd6,1'b1,1'b1, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b1, 4'd4},
        // R4: load-use on second source of a non-store
        '{5'd2,5'd6,1'b1,1'b1,1'b0,1'b0, 5'd1,5'd2,5'd6,1'b1,1'b1, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b1, 4'd4},
        // R5: store data from load in EX, no stall; MEM store bypass active
        '{5'd2,5'd6,1'b1,1'b1,1'b1,1'b0, 5'd1,5'd2,5'd6,1'b1,1'b1, 5'd0,1'b0,1'b1,5'd10,5'd10,1'b1, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b0, 4'd5},
        // R5: MEM/WB not writing, no store bypass
        '{5'd2,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd1,5'd2,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b1,5'd10,5'd10,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0, 4'd5},
        // R9: matching sources with use flags clear, no stall
        '{5'd6,5'd6,1'b0,1'b0,1'b0,1'b1, 5'd1,5'd2,5'd6,1'b1,1'b1, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0, 4'd9},
        // R8: non-branch on ALU result in EX, no stall
        '{5'd6,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd1,5'd2,5'd6,1'b1,1'b0, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0, 4'd8},
        // R6: branch on ALU result in EX stalls
        '{5'd6,5'd2,1'b1,1'b1,1'b0,1'b1, 5'd1,5'd2,5'd6,1'b1,1'b0, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b1, 4'd6},
        // R6: after the bubble, branch fed from EX/MEM and MEM/WB
        '{5'd6,5'd11,1'b1,1'b1,1'b0,1'b1, 5'd1,5'd2,5'd0,1'b0,1'b0, 5'd6,1'b1,1'b0,5'd0,5'd11,1'b1, 2'b00,2'b00,2'b10,2'b01,1'b0,1'b0, 4'd6},
        // R6: branch second source on ALU result in EX stalls
        '{5'd3,5'd7,1'b1,1'b1,1'b0,1'b1, 5'd1,5'd2,5'd7,1'b1,1'b0, 5'd0,1'b0,1'b0,5'd0,5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b1, 4'd6}
    };

    task automatic drive(input vec_t v);
        id_rs1 = v.i1; id_rs2 = v.i2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
        id_is_store = v.st; id_is_branch = v.br; ex_rs1 = v.e1; ex_rs2 = v.e2;
        idex_rd = v.xr; idex_wen = v.xwe; idex_is_load = v.xld;
        exmem_rd = v.mr; exmem_wen = v.mwe; exmem_is_store = v.mst; exmem_sdata_reg = v.md;
        memwb_rd = v.wr; memwb_wen = v.wwe;
    endtask

    task automatic check(input vec_t v, input string tag);
        n_run++;
        if (alu_sel_a !== v.fa || alu_sel_b !== v.fb || br_sel_a !== v.ba ||
            br_sel_b !== v.bb || st_data_fwd !== v.sf || stall !== v.stl) begin
            n_fail++;
            $display("FAIL %s R%0d: got a=%b b=%b ba=%b bb=%b sf=%b stall=%b exp a=%b b=%b ba=%b bb=%b sf=%b stall=%b",
                     tag, v.req, alu_sel_a, alu_sel_b, br_sel_a, br_sel_b, st_data_fwd, stall,
                     v.fa, v.fb, v.ba, v.bb, v.sf, v.stl);
        end
    endtask

    function automatic vec_t mk(input logic br, input logic [W-1:0] i1,
                                input logic [W-1:0] xr, input logic xwe, input logic xld,
                                input logic [W-1:0] mr, input logic mwe,
                                input logic [W-1:0] wr, input logic wwe,
                                input logic [1:0] ba, input logic stl, input logic [3:0] req);
        vec_t v;
        v = '0;
        v.i1 = i1; v.i2 = 5'd0; v.u1 = 1'b1; v.br = br;
        v.e1 = 5'd1; v.e2 = 5'd2; v.xr = xr; v.xwe = xwe; v.xld = xld;
        v.mr = mr; v.mwe = mwe; v.wr = wr; v.wwe = wwe;
        v.ba = ba; v.stl = stl; v.req = req;
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        vec_t v;
        drive('0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // table walk, sampled mid low phase
        for (int k = 0; k < NV; k++) begin
            @(negedge clk) drive(VECS[k]);
            #1 check(VECS[k], "table");
        end

        // R7: branch on a load in EX, cycle 1
        v = mk(1'b1, 5'd12, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 1'b1, 4'd7);
        @(negedge clk) drive(v);
        #1 check(v, "R7 first stall");
        // R7: bubble in EX, load now in EX/MEM, still stalled
        v = mk(1'b1, 5'd12, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 5'd0, 1'b0, 2'b10, 1'b1, 4'd7);
        @(negedge clk) drive(v);
        #1 check(v, "R7 second stall");
        // R7: load value now in MEM/WB, branch proceeds
        v = mk(1'b1, 5'd12, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 2'b01, 1'b0, 4'd7);
        @(negedge clk) drive(v);
        #1 check(v, "R7 released");

        // R10: branch-on-load cause seen only while reset is held
        @(negedge clk) begin
            rst_n = 1'b0;
            drive(mk(1'b1, 5'd12, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 1'b1, 4'd10));
        end
        repeat (2) @(posedge clk);
        v = mk(1'b1, 5'd12, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 1'b0, 4'd10);
        @(negedge clk) begin
            rst_n = 1'b1;
            drive(v);
        end
        #1 check(v, "R10 after reset");
        // R10: still quiet one cycle later
        @(negedge clk);
        #1 check(v, "R10 steady");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule